// File: doc/BRIEF.md
# JTAG IDCODE Pinout Scanner

This block hunts for a JTAG test port among a bank of general-purpose bidirectional channels. It tries the clock, mode-select and data-out roles on every ordered combination of three distinct channels. For each combination it drives the attached test logic into its reset state, moves it to the data-register shift state and clocks out a 32-bit word. After a TAP reset, a device that has an identification register places its ID code in the data path, so a plausible word marks a likely pinout. Data-in is never driven, because nothing needs to be shifted in to read the ID.

A host starts a scan with a channel count and a clock divider setting. Channels that hold no role in the current trial are driven high, so an unknown active-low reset line on the target stays released. When a trial captures a plausible word, the scan halts. The block then presents the three channel indices and the captured word until the host acknowledges them, and after that the search continues. A done level marks the end of the scan.

Top module: `jtag_id_scanner`

States of the scan controller: `ST_IDLE` (channels released) goes to `ST_LAUNCH` on start when at least three channels are in use, and to `ST_DONE` otherwise. `ST_LAUNCH` goes to `ST_SHIFT`, which waits for the trial sequencer to finish and then goes to `ST_JUDGE`. `ST_JUDGE` goes to `ST_REPORT` for a plausible word and to `ST_ADVANCE` for any other. `ST_REPORT` goes to `ST_ADVANCE` on acknowledge. `ST_ADVANCE` goes to `ST_LAUNCH` with the next permutation, or to `ST_DONE` after the last one. `ST_DONE` accepts start exactly as `ST_IDLE` does. States of the trial sequencer: `SQ_IDLE` goes to `SQ_LOW` on go. `SQ_LOW` goes to `SQ_HIGH` after a low half-period, and this transition is a TCK rising edge. `SQ_HIGH` goes back to `SQ_LOW` after a high half-period, or to `SQ_IDLE` after the 41st rising edge.

## Requirements
- R1: On start the block latches n = min(ch_count, NUM_CH). It then runs one trial for each ordered triple of distinct channel indices below n, which makes n(n-1)(n-2) trials, all of the same length. If n < 3 it raises done without running any trial.
- R2: Trials run in ascending order of the key (tdo index, tms index, tck index), with the tdo index most significant. The first trial is tdo=0, tms=1, tck=2. Hits are therefore reported in that order.
- R3: While a scan is in progress, the TDO channel is released (ch_oe=0). The TCK and TMS channels are driven with their role values. Every other channel, including those at index n or above, is driven high (ch_oe=1, ch_out=1). When idle or done, every ch_oe bit is 0.
- R4: TCK starts each trial low. Each high phase and each low phase lasts div_cfg+1 clock cycles. TMS changes only while TCK is low.
- R5: Each trial has 41 TCK rising edges. TMS is 1 for the first five of them, then 0, 1, 0, 0 for the next four, then 0 for the next 31 and 1 on the last.
- R6: TDO is sampled at rising edges 10 through 41. The sample taken at edge 10+k becomes bit k of the captured word, so the first bit shifted out becomes bit 0.
- R7: A captured word is plausible only if bit 0 is 1 and the word is not all ones. Any other word produces no hit, and the scan goes on without a pause.
- R8: On a plausible word, hit_valid rises with hit_tck, hit_tms, hit_tdo and hit_id. These outputs, ch_out and ch_oe all hold steady until hit_ack is sampled high. hit_valid then falls on the next cycle and the search resumes.
- R9: After the last trial, done stays high until the next start. A start seen while a scan is running is ignored.
- R10: A ch_count above NUM_CH scans exactly as NUM_CH does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (accepted when idle or done) |
| ch_count | input | CNT_W | Number of channels to scan |
| div_cfg | input | DIV_W | TCK half-period in clock cycles, minus one |
| ch_in | input | NUM_CH | Sensed level of each channel |
| ch_out | output | NUM_CH | Level driven on each channel |
| ch_oe | output | NUM_CH | Drive enable of each channel |
| hit_valid | output | 1 | A plausible ID has been captured |
| hit_ack | input | 1 | Host has taken the hit; resume |
| hit_tck | output | IDX_W | Channel that carried TCK in the hit trial |
| hit_tms | output | IDX_W | Channel that carried TMS in the hit trial |
| hit_tdo | output | IDX_W | Channel that was sampled as TDO |
| hit_id | output | 32 | Captured ID word |
| done | output | 1 | All permutations have been tried |

## Verification
The bench builds the block with NUM_CH=8 and DIV_W=4. This makes ch_count four bits wide, so values from 9 to 15 can exercise the clamp, and a full 336-trial scan fits in the run. Two behavioural TAP targets sit on disjoint channel groups. Both are reachable at eight channels, but the second lies beyond a five-channel scan, so one run checks the hit order and another checks reachability. Run times for three, four and five channels are compared to confirm that the trial count grows as n(n-1)(n-2).

// File: rtl/jscan_pkg.sv
package jscan_pkg;

    // Width of the identification word shifted out of the data register.
    localparam int ID_W        = 32;
    // Rising edges with TMS high that force Test-Logic-Reset.
    localparam int RESET_RISES = 5;
    // Rising edges that walk from reset to the shift state.
    localparam int WALK_RISES  = 4;
    localparam int TOTAL_RISES = RESET_RISES + WALK_RISES + ID_W;
    localparam int FIRST_SAMPLE = RESET_RISES + WALK_RISES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_SHIFT,
        ST_JUDGE,
        ST_REPORT,
        ST_ADVANCE,
        ST_DONE
    } scan_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOW,
        SQ_HIGH
    } seq_state_e;

    // TMS level to present ahead of rising edge number k (0-based).
    function automatic logic tms_for_rise(input int k);
        return (k < RESET_RISES) || (k == RESET_RISES + 1) || (k == TOTAL_RISES - 1);
    endfunction

    // A word counts as an ID only with its fixed LSB set and not all ones.
    function automatic logic id_plausible(input logic [ID_W-1:0] w);
        return w[0] && !(&w);
    endfunction

endpackage

// File: rtl/jscan_role_perm.sv
module jscan_role_perm
    import jscan_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int IDX_W = $clog2(NUM_CH),
    localparam int CNT_W = $clog2(NUM_CH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             step,
    input  logic [CNT_W-1:0] n_ch,
    output logic [IDX_W-1:0] tck_idx,
    output logic [IDX_W-1:0] tms_idx,
    output logic [IDX_W-1:0] tdo_idx,
    output logic             last
);

    logic [IDX_W-1:0] tck_q, tms_q, tdo_q;
    logic [IDX_W-1:0] tck_d, tms_d, tdo_d;

    // Smallest channel at or above 'from', below 'lim', excluding two indices.
    function automatic int next_free(input int from, input int ex_a, input int ex_b, input int lim);
        int r;
        r = -1;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (i >= from && i < lim && i != ex_a && i != ex_b) r = i;
        end
        return r;
    endfunction

    always_comb begin
        int lim, ct, cm, cd, c1, c2, c3, nt, nm, nd;
        lim  = int'(n_ch);
        ct   = int'(tck_q);
        cm   = int'(tms_q);
        cd   = int'(tdo_q);
        nt   = ct;
        nm   = cm;
        nd   = cd;
        last = 1'b0;
        c2   = -1;
        c3   = -1;
        c1   = next_free(ct + 1, cm, cd, lim);
        if (c1 >= 0) begin
            nt = c1;
        end else begin
            c2 = next_free(cm + 1, cd, cd, lim);
            if (c2 >= 0) begin
                nm = c2;
                nt = next_free(0, c2, cd, lim);
            end else begin
                c3 = next_free(cd + 1, NUM_CH, NUM_CH, lim);
                if (c3 >= 0) begin
                    nd = c3;
                    nm = next_free(0, c3, c3, lim);
                    nt = next_free(0, nm, c3, lim);
                end else begin
                    last = 1'b1;
                end
            end
        end
        tck_d = IDX_W'(nt);
        tms_d = IDX_W'(nm);
        tdo_d = IDX_W'(nd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            tck_q <= IDX_W'(2);
            tms_q <= IDX_W'(1);
            tdo_q <= IDX_W'(0);
        end else if (step && !last) begin
            tck_q <= tck_d;
            tms_q <= tms_d;
            tdo_q <= tdo_d;
        end
    end

    assign tck_idx = tck_q;
    assign tms_idx = tms_q;
    assign tdo_idx = tdo_q;

    // R1: the three roles never share a channel.
    a_r1_roles_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_q != tms_q) && (tms_q != tdo_q) && (tck_q != tdo_q));

    // R2: every advance moves to a strictly larger (tdo, tms, tck) key.
    a_r2_order_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last && !init) |=> ({tdo_q, tms_q, tck_q} > $past({tdo_q, tms_q, tck_q})));

endmodule

// File: rtl/jscan_tap_seq.sv
module jscan_tap_seq
    import jscan_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic            tdo_in,
    output logic            tck,
    output logic            tms,
    output logic            fin,
    output logic [ID_W-1:0] word
);

    localparam int RISE_W = $clog2(TOTAL_RISES + 1);

    seq_state_e        state_q, state_d;
    logic [DIV_W-1:0]  phase_q;
    logic [RISE_W-1:0] rises_q;
    logic              tck_q, tms_q, fin_q;
    logic [ID_W-1:0]   word_q;
    logic              half_end;

    assign half_end = (phase_q == div_cfg);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: if (go) state_d = SQ_LOW;
            SQ_LOW:  if (half_end) state_d = SQ_HIGH;
            SQ_HIGH: if (half_end)
                         state_d = (rises_q == RISE_W'(TOTAL_RISES)) ? SQ_IDLE : SQ_LOW;
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            rises_q <= '0;
            tck_q   <= 1'b0;
            tms_q   <= 1'b0;
            fin_q   <= 1'b0;
            word_q  <= '0;
        end else begin
            fin_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (go) begin
                        phase_q <= '0;
                        rises_q <= '0;
                        tck_q   <= 1'b0;
                        tms_q   <= tms_for_rise(0);
                        word_q  <= '0;
                    end
                end
                SQ_LOW: begin
                    if (half_end) begin
                        phase_q <= '0;
                        tck_q   <= 1'b1;
                        rises_q <= rises_q + 1'b1;
                        if (int'(rises_q) >= FIRST_SAMPLE)
                            word_q <= {tdo_in, word_q[ID_W-1:1]};
                    end else begin
                        phase_q <= phase_q + 1'b1;
                    end
                end
                SQ_HIGH: begin
                    if (half_end) begin
                        phase_q <= '0;
                        tck_q   <= 1'b0;
                        if (rises_q == RISE_W'(TOTAL_RISES)) fin_q <= 1'b1;
                        else                                 tms_q <= tms_for_rise(int'(rises_q));
                    end else begin
                        phase_q <= phase_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign tck  = tck_q;
    assign tms  = tms_q;
    assign fin  = fin_q;
    assign word = word_q;

    // R4: TMS holds while TCK stays high.
    a_r4_tms_quiet_high: assert property (@(posedge clk) disable iff (!rst_n)
        (tck_q && $past(tck_q)) |-> $stable(tms_q));

    // R5: the rising-edge count never runs past one trial.
    a_r5_rise_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rises_q) <= TOTAL_RISES);

    // R4: a trial ends with TCK low.
    a_r4_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> !tck_q);

endmodule

// File: rtl/jtag_id_scanner.sv
module jtag_id_scanner
    import jscan_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DIV_W  = 8,
    localparam int IDX_W = $clog2(NUM_CH),
    localparam int CNT_W = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  ch_count,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic [NUM_CH-1:0] ch_in,
    output logic [NUM_CH-1:0] ch_out,
    output logic [NUM_CH-1:0] ch_oe,
    output logic              hit_valid,
    input  logic              hit_ack,
    output logic [IDX_W-1:0]  hit_tck,
    output logic [IDX_W-1:0]  hit_tms,
    output logic [IDX_W-1:0]  hit_tdo,
    output logic [ID_W-1:0]   hit_id,
    output logic              done
);

    scan_state_e      state_q, state_d;
    logic [CNT_W-1:0] n_q, eff_n;
    logic [DIV_W-1:0] div_q;
    logic             accept, scanning;
    logic             perm_last;
    logic [IDX_W-1:0] tck_idx, tms_idx, tdo_idx;
    logic             seq_tck, seq_tms, seq_fin;
    logic [ID_W-1:0]  seq_word;
    logic             tdo_pin;
    logic [IDX_W-1:0] hit_tck_q, hit_tms_q, hit_tdo_q;
    logic [ID_W-1:0]  hit_id_q;

    assign eff_n    = (ch_count > CNT_W'(NUM_CH)) ? CNT_W'(NUM_CH) : ch_count;
    assign accept   = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign scanning = !(state_q == ST_IDLE || state_q == ST_DONE);
    assign tdo_pin  = ch_in[tdo_idx];

    jscan_role_perm #(.NUM_CH(NUM_CH)) u_perm (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (accept),
        .step    (state_q == ST_ADVANCE),
        .n_ch    (n_q),
        .tck_idx (tck_idx),
        .tms_idx (tms_idx),
        .tdo_idx (tdo_idx),
        .last    (perm_last)
    );

    jscan_tap_seq #(.DIV_W(DIV_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (state_q == ST_LAUNCH),
        .div_cfg (div_q),
        .tdo_in  (tdo_pin),
        .tck     (seq_tck),
        .tms     (seq_tms),
        .fin     (seq_fin),
        .word    (seq_word)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE:
                if (start) state_d = (eff_n < CNT_W'(3)) ? ST_DONE : ST_LAUNCH;
            ST_LAUNCH:  state_d = ST_SHIFT;
            ST_SHIFT:   if (seq_fin) state_d = ST_JUDGE;
            ST_JUDGE:   state_d = id_plausible(seq_word) ? ST_REPORT : ST_ADVANCE;
            ST_REPORT:  if (hit_ack) state_d = ST_ADVANCE;
            ST_ADVANCE: state_d = perm_last ? ST_DONE : ST_LAUNCH;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs and latched configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q       <= '0;
            div_q     <= '0;
            hit_tck_q <= '0;
            hit_tms_q <= '0;
            hit_tdo_q <= '0;
            hit_id_q  <= '0;
        end else begin
            if (accept) begin
                n_q   <= eff_n;
                div_q <= div_cfg;
            end
            if (state_q == ST_JUDGE && id_plausible(seq_word)) begin
                hit_tck_q <= tck_idx;
                hit_tms_q <= tms_idx;
                hit_tdo_q <= tdo_idx;
                hit_id_q  <= seq_word;
            end
        end
    end

    // Channel drive: roles on three channels, everything else held high.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            ch_oe[i]  = scanning && (IDX_W'(i) != tdo_idx);
            if (!scanning)                  ch_out[i] = 1'b0;
            else if (IDX_W'(i) == tck_idx)  ch_out[i] = seq_tck;
            else if (IDX_W'(i) == tms_idx)  ch_out[i] = seq_tms;
            else                            ch_out[i] = 1'b1;
        end
    end

    assign hit_valid = (state_q == ST_REPORT);
    assign done      = (state_q == ST_DONE);
    assign hit_tck   = hit_tck_q;
    assign hit_tms   = hit_tms_q;
    assign hit_tdo   = hit_tdo_q;
    assign hit_id    = hit_id_q;

    // R3: during a scan exactly one channel is released.
    a_r3_one_released: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |-> ($countones(~ch_oe) == 1));

    // R3: idle or done leaves all channels undriven.
    a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid == 1'b0 && (done || state_q == ST_IDLE)) |-> (ch_oe == '0));

    // R7: only plausible words are ever reported.
    a_r7_plausible_only: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (hit_id[0] && !(&hit_id)));

    // R8: a pending hit and the channel pins freeze until acknowledged.
    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !hit_ack) |=> (hit_valid && $stable(hit_id) && $stable(hit_tdo) && $stable(ch_out)));

    // R8: acknowledge retires the hit on the next cycle.
    a_r8_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_ack) |=> !hit_valid);

    // R9: done persists until a start arrives.
    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

// File: tb/test_jtag_id_scanner.sv
`timescale 1ns/1ps

module test_tap_model (
    input  logic        tck,
    input  logic        tms,
    input  logic [31:0] id,
    output logic        tdo
);
    localparam logic [2:0] M_TLR = 3'd0, M_RTI = 3'd1, M_SEL = 3'd2,
                           M_CAP = 3'd3, M_SHD = 3'd4, M_OTH = 3'd5;
    logic [2:0]  st = M_TLR;
    logic [2:0]  ones = 3'd0;
    logic [31:0] sr = 32'hFFFF_FFFF;
    initial tdo = 1'b1;

    always @(posedge tck) begin
        ones <= tms ? ((ones == 3'd5) ? ones : ones + 3'd1) : 3'd0;
        if (tms && ones >= 3'd4) st <= M_TLR;
        else begin
            case (st)
                M_TLR: st <= tms ? M_TLR : M_RTI;
                M_RTI: st <= tms ? M_SEL : M_RTI;
                M_SEL: st <= tms ? M_OTH : M_CAP;
                M_CAP: begin sr <= id; st <= tms ? M_OTH : M_SHD; end
                M_SHD: begin sr <= {1'b1, sr[31:1]}; st <= tms ? M_OTH : M_SHD; end
                default: st <= M_OTH;
            endcase
        end
    end

    always @(negedge tck) tdo <= (st == M_SHD) ? sr[0] : 1'b1;
endmodule

module test_jtag_id_scanner;
    localparam int NUM_CH = 8;
    localparam int DIV_W  = 4;
    localparam int IDX_W  = 3;
    localparam int CNT_W  = 4;
    // target A on tck 0, tms 1, tdo 2; target B on tck 5, tms 3, tdo 4
    localparam int A_T = 0, A_M = 1, A_D = 2;
    localparam int B_T = 5, B_M = 3, B_D = 4;

    typedef struct packed {
        logic [IDX_W-1:0] t;
        logic [IDX_W-1:0] m;
        logic [IDX_W-1:0] d;
        logic [31:0]      id;
    } hit_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  ch_count = '0;
    logic [DIV_W-1:0]  div_cfg = '0;
    logic [NUM_CH-1:0] ch_in, ch_out, ch_oe;
    logic              hit_valid, hit_ack = 1'b0, done;
    logic [IDX_W-1:0]  hit_tck, hit_tms, hit_tdo;
    logic [31:0]       hit_id;
    logic [31:0]       a_id = 32'hFFFF_FFFF, b_id = 32'hFFFF_FFFF;
    logic              a_tdo, b_tdo;

    int   n_checks = 0, n_fail = 0, hits_seen = 0;
    hit_t exp_q[$];

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) ch_in[i] = ch_oe[i] ? ch_out[i] : 1'b1;
        if (!ch_oe[A_D]) ch_in[A_D] = a_tdo;
        if (!ch_oe[B_D]) ch_in[B_D] = b_tdo;
    end

    test_tap_model u_tap_a (.tck(ch_in[A_T]), .tms(ch_in[A_M]), .id(a_id), .tdo(a_tdo));
    test_tap_model u_tap_b (.tck(ch_in[B_T]), .tms(ch_in[B_M]), .id(b_id), .tdo(b_tdo));

    jtag_id_scanner #(.NUM_CH(NUM_CH), .DIV_W(DIV_W)) i_jtag_id_scanner (
        .clk(clk), .rst_n(rst_n), .start(start), .ch_count(ch_count), .div_cfg(div_cfg),
        .ch_in(ch_in), .ch_out(ch_out), .ch_oe(ch_oe), .hit_valid(hit_valid), .hit_ack(hit_ack),
        .hit_tck(hit_tck), .hit_tms(hit_tms), .hit_tdo(hit_tdo), .hit_id(hit_id), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_hit(input int t, input int m, input int d, input logic [31:0] id);
        hit_t e;
        e.t = IDX_W'(t); e.m = IDX_W'(m); e.d = IDX_W'(d); e.id = id;
        exp_q.push_back(e);
    endtask

    task automatic pulse_start(input int n, input int dv);
        @(negedge clk);
        ch_count = CNT_W'(n);
        div_cfg  = DIV_W'(dv);
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    // Runs a scan to done; optionally probes channel drive mid-scan.
    task automatic run_scan(input int n, input int dv, input bit probe, output int cycles);
        pulse_start(n, dv);
        cycles = 1;
        while (!done) begin
            @(negedge clk);
            cycles++;
            if (probe && cycles == 20) begin
                check($countones(~ch_oe) == 1, "R3", "one released channel", 64'(ch_oe), 64'd0);
                check(ch_oe[7:5] == 3'b111 && ch_out[7:5] == 3'b111, "R3",
                      "channels beyond n driven high", 64'({ch_oe[7:5], ch_out[7:5]}), 64'h3F);
            end
        end
    endtask

    task automatic finish_run(input string req, input int hits_before, input int hits_exp);
        check(exp_q.size() == 0, req, "expected hits all reported", 64'(exp_q.size()), 64'd0);
        check(hits_seen - hits_before == hits_exp, req, "hit count", 64'(hits_seen - hits_before),
              64'(hits_exp));
        repeat (3) @(negedge clk);
        check(done && ch_oe == '0, "R9", "done held, channels released", 64'({done, ch_oe}),
              64'h100);
        exp_q.delete();
    endtask

    // Scoreboard monitor: pops the expected item for every hit and acknowledges it.
    initial begin
        forever begin
            @(negedge clk);
            if (hit_valid) begin
                hit_t act, e;
                logic [NUM_CH-1:0] pins;
                bit steady;
                act.t = hit_tck; act.m = hit_tms; act.d = hit_tdo; act.id = hit_id;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected hit", 64'(act), 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    // R2 order, R5 TMS walk, R6 bit order all show in this word
                    check(act == e, "R2/R5/R6", "hit fields", 64'(act), 64'(e));
                end
                pins = ch_out;
                steady = 1'b1;
                repeat (6) begin
                    @(negedge clk);
                    if (!hit_valid || {hit_tck, hit_tms, hit_tdo, hit_id} != act ||
                        ch_out != pins || done) steady = 1'b0;
                end
                check(steady, "R8", "hit and pins frozen until ack", 64'(steady), 64'd1);
                hit_ack = 1'b1;
                @(negedge clk);
                hit_ack = 1'b0;
                check(!hit_valid, "R8", "valid drops after ack", 64'(hit_valid), 64'd0);
                hits_seen++;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int t3, t4, t5, t2, c, hb, hi, lo, guard;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ch_oe == '0 && !hit_valid && !done, "R3", "reset state",
              64'({ch_oe, hit_valid, done}), 64'd0);

        // R1 / R7: all-ones IDs everywhere, so no trial pauses; time three counts.
        hb = hits_seen;
        run_scan(3, 0, 1'b0, t3);
        finish_run("R7", hb, 0);
        run_scan(4, 0, 1'b0, t4);
        run_scan(5, 0, 1'b1, t5);
        c = (t4 - t3) / 18;
        check((t4 - t3) % 18 == 0 && c > 41, "R1", "per-trial cost from 6 vs 24 trials",
              64'(t4 - t3), 64'(18 * c));
        check(t5 == t3 + 54 * c, "R1", "5 channels run 60 trials", 64'(t5), 64'(t3 + 54 * c));
        finish_run("R1", hb, 0);

        // R1: fewer than three channels gives done with no trial.
        hb = hits_seen;
        pulse_start(2, 0);
        t2 = 0;
        repeat (4) begin @(negedge clk); t2 += ch_oe != '0 ? 1 : 0; end
        check(done && t2 == 0, "R1", "n=2 done with no drive", 64'({done, 8'(t2)}), 64'h100);
        finish_run("R1", hb, 0);

        // R7: a device left in bypass returns bit 0 = 0.
        a_id = 32'hFFFF_FFFE;
        hb = hits_seen;
        run_scan(3, 0, 1'b0, t2);
        finish_run("R7", hb, 0);

        // R7 boundary and R4 timing: LSB-only word accepted, TCK phases at div 2.
        a_id = 32'h0000_0001;
        hb = hits_seen;
        expect_hit(A_T, A_M, A_D, a_id);
        pulse_start(3, 2);
        guard = 0;
        while (!(ch_oe[2] && ch_out[2]) && guard < 100) begin @(negedge clk); guard++; end
        hi = 0;
        while (ch_out[2] && hi < 100) begin @(negedge clk); hi++; end
        lo = 0;
        while (!ch_out[2] && lo < 100) begin @(negedge clk); lo++; end
        check(hi == 3, "R4", "TCK high phase cycles", 64'(hi), 64'd3);
        check(lo == 3, "R4", "TCK low phase cycles", 64'(lo), 64'd3);
        while (!done) @(negedge clk);
        finish_run("R7", hb, 1);

        // R2 / R10 / R9: two targets, ch_count 15 clamps to 8, stray start mid-scan.
        a_id = 32'h4BA0_0477;
        b_id = 32'h0471_017F;
        hb = hits_seen;
        expect_hit(A_T, A_M, A_D, a_id);
        expect_hit(B_T, B_M, B_D, b_id);
        pulse_start(15, 1);
        repeat (300) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done, "R9", "start while scanning ignored", 64'(done), 64'd0);
        while (!done) @(negedge clk);
        finish_run("R10", hb, 2);

        // R1: five channels reach target A but not target B.
        hb = hits_seen;
        expect_hit(A_T, A_M, A_D, a_id);
        run_scan(5, 0, 1'b0, t2);
        finish_run("R1", hb, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule